// File: doc/BRIEF.md
# Multi-Mode 16-Bit PWM Timer

This block is a 16-bit up/down timer that produces two waveform outputs, A and B. A 4-bit mode input chooses how the counter runs. It can free-run to all-ones. It can clear when it reaches a TOP value. It can count up and then wrap, for single-slope PWM. It can count up and then down, for dual-slope PWM with centred pulses. The TOP value comes from a fixed 8-, 9- or 10-bit limit, from compare register A, or from a capture-style limit register. Each counting step is gated by a one-cycle enable tick, so a prescaler outside the block sets the counting rate.

Compare registers A and B are double-buffered in the PWM modes. A write goes to a shadow copy, and that copy is moved to the active register at one fixed point of the count cycle. This means a new duty value never cuts a period short. In the non-PWM modes a write takes effect at once. The limit register is always written directly. Each output is controlled by a 2-bit action code. The code's meaning depends on the mode and, in the dual-slope modes, on the counting direction. A per-channel enable output shows whether the channel is driving its pin.

Top module: `pwm_timer16`

## Requirements
- R1: After reset the count is 0, the direction is up, all compare, shadow and limit registers are 0, and both pins, both enables, the overflow flag and both match strobes are 0.
- R2: The count changes only on a clock edge where `tick` is 1. Mode 13 leaves the count frozen, raises no flags and disconnects both outputs.
- R3: Mode 0 counts 0 to 0xFFFF and wraps. Compare writes take effect at once. `ovf` pulses for one cycle after the tick taken at 0xFFFF. Action code 2'b10 clears the pin on a match, 2'b11 sets it, and 2'b01 disconnects the output.
- R4: Mode 4 takes TOP from compare A and mode 12 takes it from the limit register. The count returns to 0 after the tick taken at TOP. `ovf` is raised only by the tick taken at 0xFFFF.
- R5: Single-slope PWM (modes 5/6/7 with TOP 0xFF/0x1FF/0x3FF, mode 14 with TOP from the limit register, mode 15 with TOP from compare A) counts 0..TOP and wraps. `ovf` pulses after the tick taken at TOP.
- R6: In single-slope PWM, code 2'b10 clears the pin on a match and sets it on the wrap to 0. Code 2'b11 does the opposite. When a match and a wrap happen on the same tick, the wrap action wins.
- R7: Dual-slope modes (1/2/3 with fixed TOP 0xFF/0x1FF/0x3FF, 8 and 10 with TOP from the limit register, 9 and 11 with TOP from compare A) count up to TOP and down to 0. Each end value lasts exactly one tick. `ovf` pulses after the tick taken at 0 while counting down.
- R8: In the dual-slope modes, code 2'b10 clears the pin on a match while counting up and sets it on a match while counting down. Code 2'b11 does the reverse.
- R9: In the dual-slope modes, code 2'b01 makes pin A toggle on each match in modes 8 to 11 only. In modes 1 to 3 it disconnects A. Code 2'b01 always disconnects B.
- R10: Compare writes are held in the shadow registers. The shadow is copied to the active register on the tick taken at TOP in modes 1/2/3/10/11, and on the tick taken at 0 in modes 5 to 9, 14 and 15.
- R11: `cmpa_hit` and `cmpb_hit` each pulse for one cycle after a tick on which the count equals that channel's active compare value, in any mode except 13.
- R12: Code 2'b00 disconnects a channel. A disconnected channel has its enable output at 0 and its pin held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one step per high cycle |
| mode | input | 4 | Waveform mode select |
| coma | input | 2 | Action code for output A |
| comb | input | 2 | Action code for output B |
| wdata | input | 16 | Write data for the register ports |
| wr_ocra | input | 1 | Write compare A |
| wr_ocrb | input | 1 | Write compare B |
| wr_lim | input | 1 | Write limit register |
| count | output | 16 | Current count |
| oca | output | 1 | Waveform pin A |
| ocb | output | 1 | Waveform pin B |
| oca_en | output | 1 | Output A connected |
| ocb_en | output | 1 | Output B connected |
| ovf | output | 1 | Overflow flag pulse |
| cmpa_hit | output | 1 | Compare A match pulse |
| cmpb_hit | output | 1 | Compare B match pulse |

## Verification
The hardest case to reach is a shadow register that is written partway through a period. The write must stay invisible until the next load point and then take effect. The bench first loads its starting values in mode 0, where writes are immediate, and then switches to the PWM mode. This gives a known starting TOP and known duty values. It then writes a new compare value while the count is between the old match point and the load point. With that timing, an immediate update would move a pin edge or a reversal point to a place the bench checks. The stimulus also lines the compare value up with TOP in single-slope PWM, so that a match and a wrap land on the same tick.

// File: rtl/pwm_timer16.sv
`timescale 1ns/1ps
module pwm_timer16 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [3:0]   mode,
  input  logic [1:0]   coma,
  input  logic [1:0]   comb,
  input  logic [W-1:0] wdata,
  input  logic         wr_ocra,
  input  logic         wr_ocrb,
  input  logic         wr_lim,
  output logic [W-1:0] count,
  output logic         oca,
  output logic         ocb,
  output logic         oca_en,
  output logic         ocb_en,
  output logic         ovf,
  output logic         cmpa_hit,
  output logic         cmpb_hit
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] T8   = W'(255);
  localparam logic [W-1:0] T9   = W'(511);
  localparam logic [W-1:0] T10  = W'(1023);

  logic [W-1:0] ocra_q, ocrb_q, bufa_q, bufb_q, lim_q, top;
  logic         up_q;

  wire m_idle = (mode == 4'd13);
  wire m_dual = mode inside {4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11};
  wire m_fast = mode inside {4'd5, 4'd6, 4'd7, 4'd14, 4'd15};
  wire m_pfc  = mode inside {4'd8, 4'd9};
  wire m_tog  = mode inside {4'd8, 4'd9, 4'd10, 4'd11};
  wire m_imm  = !m_dual && !m_fast;

  always_comb begin
    case (mode)
      4'd1, 4'd5:                  top = T8;
      4'd2, 4'd6:                  top = T9;
      4'd3, 4'd7:                  top = T10;
      4'd4, 4'd9, 4'd11, 4'd15:    top = ocra_q;
      4'd8, 4'd10, 4'd12, 4'd14:   top = lim_q;
      default:                     top = MAXV;
    endcase
  end

  wire at_top = (count == top);
  wire at_bot = (count == '0);
  wire hit_a  = (count == ocra_q);
  wire hit_b  = (count == ocrb_q);
  wire step   = tick && !m_idle;
  wire load   = tick && ((m_fast || m_pfc) ? at_bot : (m_dual && at_top));
  wire a_en_d = !m_idle && ((coma == 2'b01) ? m_tog : (coma != 2'b00));
  wire b_en_d = !m_idle && comb[1];

  function automatic logic pin_upd(input logic [1:0] code, input logic cur,
                                   input logic hit, input logic wrap,
                                   input logic dual, input logic fast,
                                   input logic up);
    if (code == 2'b01)
      return hit ? ~cur : cur;
    if (dual)
      return hit ? (up ? code[0] : ~code[0]) : cur;
    if (fast)
      return wrap ? ~code[0] : (hit ? code[0] : cur);
    return hit ? code[0] : cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      up_q  <= 1'b1;
    end else if (step) begin
      if (m_dual) begin
        if (up_q) begin
          if (count >= top) begin
            up_q  <= 1'b0;
            count <= at_bot ? '0 : count - 1'b1;
          end else begin
            count <= count + 1'b1;
          end
        end else if (at_bot) begin
          up_q  <= 1'b1;
          count <= count + 1'b1;
        end else begin
          count <= count - 1'b1;
        end
      end else begin
        count <= at_top ? '0 : count + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ocra_q <= '0;
      ocrb_q <= '0;
      bufa_q <= '0;
      bufb_q <= '0;
      lim_q  <= '0;
    end else begin
      if (wr_lim) lim_q <= wdata;
      if (wr_ocra) bufa_q <= wdata;
      if (wr_ocrb) bufb_q <= wdata;
      if (wr_ocra && m_imm)    ocra_q <= wdata;
      else if (load && !m_imm) ocra_q <= bufa_q;
      if (wr_ocrb && m_imm)    ocrb_q <= wdata;
      else if (load && !m_imm) ocrb_q <= bufb_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf      <= 1'b0;
      cmpa_hit <= 1'b0;
      cmpb_hit <= 1'b0;
    end else begin
      ovf      <= step && (m_dual ? (at_bot && !up_q) :
                           m_fast ? at_top : (count == MAXV));
      cmpa_hit <= step && hit_a;
      cmpb_hit <= step && hit_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oca    <= 1'b0;
      ocb    <= 1'b0;
      oca_en <= 1'b0;
      ocb_en <= 1'b0;
    end else begin
      oca_en <= a_en_d;
      ocb_en <= b_en_d;
      if (!a_en_d)   oca <= 1'b0;
      else if (tick) oca <= pin_upd(coma, oca, hit_a, at_top, m_dual, m_fast, up_q);
      if (!b_en_d)   ocb <= 1'b0;
      else if (tick) ocb <= pin_upd(comb, ocb, hit_b, at_top, m_dual, m_fast, up_q);
    end
  end
endmodule

// File: rtl/pwm_timer16_chk.sv
`timescale 1ns/1ps
module pwm_timer16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [3:0]   mode,
  input logic [W-1:0] count,
  input logic         oca,
  input logic         ocb,
  input logic         oca_en,
  input logic         ocb_en,
  input logic         ovf,
  input logic         cmpa_hit,
  input logic         cmpb_hit
);
  // R2
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd13) |=> $stable(count));
  // R3
  ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> ($past(tick) && $past(mode) != 4'd13));
  // R11
  hita_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpa_hit |-> $past(tick));
  // R11
  hitb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpb_hit |-> $past(tick));
  // R12
  dis_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oca_en |-> !oca);
  // R12
  dis_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ocb_en |-> !ocb);
endmodule

bind pwm_timer16 pwm_timer16_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .count(count),
  .oca(oca), .ocb(ocb), .oca_en(oca_en), .ocb_en(ocb_en), .ovf(ovf),
  .cmpa_hit(cmpa_hit), .cmpb_hit(cmpb_hit)
);

// File: tb/tb_pwm_timer16.sv
`timescale 1ns/1ps
module tb_pwm_timer16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic [1:0]  coma = 2'b00;
  logic [1:0]  comb = 2'b00;
  logic [15:0] wdata = '0;
  logic        wr_ocra = 1'b0, wr_ocrb = 1'b0, wr_lim = 1'b0;
  logic [15:0] count;
  logic        oca, ocb, oca_en, ocb_en, ovf, cmpa_hit, cmpb_hit;

  pwm_timer16 dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .coma(coma), .comb(comb),
    .wdata(wdata), .wr_ocra(wr_ocra), .wr_ocrb(wr_ocrb), .wr_lim(wr_lim),
    .count(count), .oca(oca), .ocb(ocb), .oca_en(oca_en), .ocb_en(ocb_en),
    .ovf(ovf), .cmpa_hit(cmpa_hit), .cmpb_hit(cmpb_hit)
  );

  always #2 clk = ~clk;

  typedef enum {S_CNT, S_OCA, S_OCB, S_AEN, S_BEN, S_OVF, S_HA, S_HB} sig_e;
  typedef struct {
    sig_e        s;
    logic [15:0] v;
    string       r;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [15:0] actual(sig_e s);
    case (s)
      S_CNT:   return count;
      S_OCA:   return 16'(oca);
      S_OCB:   return 16'(ocb);
      S_AEN:   return 16'(oca_en);
      S_BEN:   return 16'(ocb_en);
      S_OVF:   return 16'(ovf);
      S_HA:    return 16'(cmpa_hit);
      default: return 16'(cmpb_hit);
    endcase
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] a;
        it = q.pop_front();
        a = actual(it.s);
        checks++;
        if (a !== it.v) begin
          errors++;
          $display("FAIL %s: %s actual=%0h expected=%0h", it.r, it.s.name(), a, it.v);
        end
      end
    end
  end

  task automatic exp(sig_e s, logic [15:0] v, string r);
    item_t it;
    it.s = s; it.v = v; it.r = r;
    q.push_back(it);
  endtask

  task automatic run(int n, bit t);
    tick = t;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr(int which, logic [15:0] v);
    wdata = v;
    case (which)
      0: wr_ocra = 1'b1;
      1: wr_ocrb = 1'b1;
      default: wr_lim = 1'b1;
    endcase
    @(negedge clk);
    wr_ocra = 1'b0; wr_ocrb = 1'b0; wr_lim = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int vee_at(int k, int t);
    int p;
    p = k % (2 * t);
    return (p <= t) ? p : 2 * t - p;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    exp(S_CNT, 0, "R1"); exp(S_OCA, 0, "R1"); exp(S_OCB, 0, "R1");
    exp(S_AEN, 0, "R1"); exp(S_OVF, 0, "R1"); exp(S_HA, 0, "R1");

    // R3 normal mode
    wr(0, 3);
    coma = 2'b11; comb = 2'b01;
    @(negedge clk);
    exp(S_AEN, 1, "R3"); exp(S_BEN, 0, "R3"); exp(S_OCB, 0, "R12");
    run(3, 1); exp(S_CNT, 3, "R3"); exp(S_OCA, 0, "R3");
    run(1, 1); exp(S_CNT, 4, "R3"); exp(S_OCA, 1, "R3"); exp(S_HA, 1, "R11");
    run(5, 0); exp(S_CNT, 4, "R2"); exp(S_HA, 0, "R11");
    coma = 2'b10;
    run(65531, 1); exp(S_CNT, 16'hFFFF, "R3"); exp(S_OVF, 0, "R3"); exp(S_OCA, 1, "R3");
    run(1, 1); exp(S_CNT, 0, "R3"); exp(S_OVF, 1, "R3");
    run(1, 1); exp(S_CNT, 1, "R3"); exp(S_OVF, 0, "R3");
    run(3, 1); exp(S_CNT, 4, "R3"); exp(S_OCA, 0, "R3");
    coma = 2'b11;
    wr(0, 6);
    run(2, 1); exp(S_CNT, 6, "R3"); exp(S_OCA, 0, "R3");
    run(1, 1); exp(S_CNT, 7, "R3"); exp(S_OCA, 1, "R3");

    // R4 CTC modes
    do_reset();
    wr(0, 5);
    mode = 4'd4;
    run(5, 1); exp(S_CNT, 5, "R4");
    run(1, 1); exp(S_CNT, 0, "R4"); exp(S_OVF, 0, "R4"); exp(S_HA, 1, "R11");
    mode = 4'd12;
    wr(2, 2);
    run(2, 1); exp(S_CNT, 2, "R4");
    run(1, 1); exp(S_CNT, 0, "R4"); exp(S_OVF, 0, "R4");

    // R5 fixed-TOP single-slope
    mode = 4'd5; do_reset();
    run(255, 1); exp(S_CNT, 255, "R5"); exp(S_OVF, 0, "R5");
    run(1, 1); exp(S_CNT, 0, "R5"); exp(S_OVF, 1, "R5");
    mode = 4'd7; do_reset();
    run(1023, 1); exp(S_CNT, 1023, "R5");
    run(1, 1); exp(S_CNT, 0, "R5"); exp(S_OVF, 1, "R5");

    // R6 / R10 single-slope, TOP from limit register
    mode = 4'd0; coma = 2'b00; comb = 2'b00; do_reset();
    wr(2, 9); wr(0, 4); wr(1, 3);
    mode = 4'd14; coma = 2'b10; comb = 2'b11;
    @(negedge clk);
    run(4, 1); exp(S_CNT, 4, "R5"); exp(S_OCA, 0, "R6"); exp(S_OCB, 1, "R6");
    run(5, 1); exp(S_CNT, 9, "R5"); exp(S_OCA, 0, "R6");
    run(1, 1); exp(S_CNT, 0, "R5"); exp(S_OVF, 1, "R5");
    exp(S_OCA, 1, "R6"); exp(S_OCB, 0, "R6");
    run(2, 1);
    wr(0, 7);
    run(3, 1); exp(S_CNT, 5, "R10"); exp(S_OCA, 0, "R10");
    run(5, 1); exp(S_CNT, 0, "R6"); exp(S_OCA, 1, "R6");
    run(5, 1); exp(S_CNT, 5, "R10"); exp(S_OCA, 1, "R10");
    run(3, 1); exp(S_CNT, 8, "R10"); exp(S_OCA, 0, "R10");
    wr(0, 9);
    run(2, 1); exp(S_CNT, 0, "R6"); exp(S_OCA, 1, "R6");
    run(9, 1); exp(S_CNT, 9, "R6"); exp(S_OCA, 1, "R6");
    run(1, 1); exp(S_CNT, 0, "R6"); exp(S_OCA, 1, "R6"); exp(S_HA, 1, "R11");

    // R7 / R8 / R10 dual-slope, TOP from limit register
    mode = 4'd0; coma = 2'b00; comb = 2'b00; do_reset();
    wr(2, 4); wr(0, 2); wr(1, 2);
    mode = 4'd10; coma = 2'b10; comb = 2'b11;
    @(negedge clk);
    for (int k = 1; k <= 16; k++) begin
      if (k == 10) wr(0, 1);
      run(1, 1);
      exp(S_CNT, 16'(vee_at(k, 4)), "R7");
      case (k)
        3:  begin exp(S_OCA, 0, "R8"); exp(S_OCB, 1, "R8"); end
        5:  exp(S_OVF, 0, "R7");
        7:  begin exp(S_OCA, 1, "R8"); exp(S_OCB, 0, "R8"); exp(S_HA, 1, "R11"); end
        8:  exp(S_OVF, 0, "R7");
        9:  exp(S_OVF, 1, "R7");
        10: exp(S_OCA, 1, "R10");
        11: exp(S_OCA, 0, "R10");
        15: exp(S_OCA, 0, "R10");
        16: exp(S_OCA, 1, "R10");
        default: ;
      endcase
    end

    // R9 / R10 dual-slope with toggle, TOP from compare A
    mode = 4'd0; coma = 2'b00; comb = 2'b00; do_reset();
    wr(0, 3);
    mode = 4'd9; coma = 2'b01; comb = 2'b01;
    @(negedge clk);
    exp(S_AEN, 1, "R9"); exp(S_BEN, 0, "R9");
    run(1, 1); exp(S_CNT, 1, "R7");
    wr(0, 5);
    run(2, 1); exp(S_CNT, 3, "R10"); exp(S_OCA, 0, "R9");
    run(1, 1); exp(S_CNT, 2, "R10"); exp(S_OCA, 1, "R9");
    run(3, 1); exp(S_CNT, 1, "R7"); exp(S_OVF, 1, "R7");
    run(3, 1); exp(S_CNT, 4, "R10");
    run(1, 1); exp(S_CNT, 5, "R10"); exp(S_OCA, 1, "R9");
    run(1, 1); exp(S_CNT, 4, "R10"); exp(S_OCA, 0, "R9"); exp(S_OCB, 0, "R9");
    mode = 4'd2;
    @(negedge clk);
    exp(S_AEN, 0, "R9"); exp(S_OCA, 0, "R12");

    // R2 reserved mode freezes counter
    mode = 4'd13; coma = 2'b10;
    @(negedge clk);
    exp(S_AEN, 0, "R2");
    run(5, 1); exp(S_CNT, 4, "R2"); exp(S_OVF, 0, "R2"); exp(S_HA, 0, "R2");

    @(negedge clk);
    #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule